// File: doc/BRIEF.md
# List-Sequenced Block Transfer Controller

This controller sits in a backplane crate. It moves a block of 24-bit data words between a word stream that is fed from the serial link and the modules on the parallel backplane. The host first loads up to four address lists through a write port. It then issues a transfer command. The command picks one of two addressing schemes. In fixed mode, every word of the block is sent to the same module, function and subaddress. In list mode, each successive word takes its module, function and subaddress from the next entry of the chosen list.

Each word produces one single-cycle backplane strobe. Strobes are paced by a counter clocked from the system clock. A write transfer takes words from the input stream and drives them onto the backplane. A read transfer captures the data the module returns and presents it on the output stream. The transfer finishes with a one-cycle done pulse. It also finishes early, with an error flag, when a module does not answer a strobe.

Top module: `lsbt_ctrl`

## Requirements
- R1: After reset the controller is idle: `cmd_ready`=1 and `busy`, `bp_strobe`, `done`, `err`, `out_valid` and `in_ready` are all 0.
- R2: In a write transfer (`cmd_write`=1), the k-th word accepted on the input stream appears on `bp_wdata`, with `bp_write`=1, during the k-th strobe of the block.
- R3: In a read transfer, the `bp_rdata` value present during the k-th strobe becomes the k-th output-stream word. `out_valid` and `out_data` hold steady while `out_ready` is low.
- R4: In fixed mode (`cmd_list_mode`=0), every strobe of the block carries the command's `cmd_mod`, `cmd_fn` and `cmd_sub`.
- R5: In list mode, strobe k (counting from 0) carries entry k mod L of the selected list, where L is that list's stored length. A length of 0 or 1 repeats entry 0. An entry is 14 bits: [13:9] module number, [8:4] function code, [3:0] subaddress.
- R6: The four lists keep independent contents and lengths. `cmd_list` selects which list a transfer uses.
- R7: Two strobes of one transfer are always at least WORD_CLKS cycles apart. When data or output space is always available, they are exactly WORD_CLKS cycles apart.
- R8: After the strobe of the last word, `done` pulses for one cycle and the controller returns to idle. A block of N words makes exactly N strobes.
- R9: When `bp_noresp` is high during a strobe, the transfer ends after that strobe, `done` pulses and `err` rises. `err` stays high until the next command is accepted. A read word whose strobe drew no response is not delivered.
- R10: Writes to list entries or list lengths are ignored while `busy` is high.
- R11: A command with a word count of 0 completes with a done pulse and no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lw_ent_en | input | 1 | Write one list entry |
| lw_len_en | input | 1 | Write one list length |
| lw_list | input | 2 | List selected for the write |
| lw_idx | input | 6 | Entry index for the write |
| lw_entry | input | 14 | Entry value {module, function, subaddress} |
| lw_len | input | 7 | Length value (1 to 64) |
| cmd_valid | input | 1 | Transfer command offered |
| cmd_ready | output | 1 | Controller idle; command taken |
| cmd_list_mode | input | 1 | 1 = list mode, 0 = fixed mode |
| cmd_write | input | 1 | 1 = stream to backplane, 0 = backplane to stream |
| cmd_list | input | 2 | List used in list mode |
| cmd_count | input | 16 | Words in the block |
| cmd_mod | input | 5 | Fixed-mode module number |
| cmd_fn | input | 5 | Fixed-mode function code |
| cmd_sub | input | 4 | Fixed-mode subaddress |
| in_valid | input | 1 | Input word offered |
| in_ready | output | 1 | Input word taken this cycle |
| in_data | input | 24 | Input word |
| out_valid | output | 1 | Output word available |
| out_ready | input | 1 | Output word taken |
| out_data | output | 24 | Output word |
| bp_strobe | output | 1 | One-cycle backplane command strobe |
| bp_write | output | 1 | Direction of the current strobe |
| bp_mod | output | 5 | Module number of the strobe |
| bp_fn | output | 5 | Function code of the strobe |
| bp_sub | output | 4 | Subaddress of the strobe |
| bp_wdata | output | 24 | Data driven on a write strobe |
| bp_rdata | input | 24 | Data returned on a read strobe |
| bp_noresp | input | 1 | Module did not answer the strobe |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle end-of-transfer pulse |
| err | output | 1 | Last transfer ended without a response |

## Verification
The hardest condition to reach from the ports is a list-table write that lands in the middle of a running list transfer, at a point where the transfer will go back and read the targeted entries again. The bench starts a long transfer on a five-entry list. Several cycles into it, from a parallel thread, it overwrites those entries and the list's length. It then checks every later strobe against the original contents, both for the rest of that block and for a fresh transfer afterwards. The index wrap is reached by sending 70-word blocks through lists of length 1, 3, 5 and 64. The early-abort paths are reached by raising the no-response input on one chosen strobe.

// File: rtl/lsbt_pkg.sv
`timescale 1ns/1ps
package lsbt_pkg;
    localparam int DATA_W  = 24;
    localparam int MOD_W   = 5;
    localparam int FN_W    = 5;
    localparam int SUB_W   = 4;
    localparam int ENTRY_W = MOD_W + FN_W + SUB_W;

    // Backplane address of one word: [13:9] module, [8:4] function, [3:0] subaddress
    typedef struct packed {
        logic [MOD_W-1:0] modn;
        logic [FN_W-1:0]  fn;
        logic [SUB_W-1:0] sub;
    } bp_addr_t;

    typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_STB} xfer_st_t;
endpackage

// File: rtl/lsbt_pace.sv
`timescale 1ns/1ps
module lsbt_pace #(
    parameter int WORD_CLKS = 250,
    localparam int CW = $clog2(WORD_CLKS + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic fire,
    output logic slot
);
    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clear)
            cnt_d = '0;
        else if (fire)
            cnt_d = CW'(WORD_CLKS - 1);
        else if (cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign slot = (cnt_q == '0);

    // R7: a word slot is closed for the cycle after a word is issued
    a_r7_slot_closes: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && !clear) |=> !slot);
endmodule

// File: rtl/lsbt_list_mem.sv
`timescale 1ns/1ps
module lsbt_list_mem
    import lsbt_pkg::*;
#(
    parameter int LIST_DEPTH = 64,
    parameter int NUM_LISTS  = 4,
    localparam int IDX_W  = $clog2(LIST_DEPTH),
    localparam int LEN_W  = IDX_W + 1,
    localparam int LSEL_W = $clog2(NUM_LISTS),
    localparam int TOTAL  = NUM_LISTS * LIST_DEPTH
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               lock,
    input  logic               ent_we,
    input  logic               len_we,
    input  logic [LSEL_W-1:0]  wr_list,
    input  logic [IDX_W-1:0]   wr_idx,
    input  logic [ENTRY_W-1:0] wr_ent,
    input  logic [LEN_W-1:0]   wr_len,
    input  logic [LSEL_W-1:0]  rd_list,
    input  logic [IDX_W-1:0]   rd_idx,
    output logic [ENTRY_W-1:0] rd_ent,
    output logic [LEN_W-1:0]   rd_len
);
    logic [ENTRY_W-1:0]         ent_q [TOTAL];
    logic [NUM_LISTS*LEN_W-1:0] len_d, len_q;
    int unsigned                waddr, raddr;

    assign waddr = int'(wr_list) * LIST_DEPTH + int'(wr_idx);
    assign raddr = int'(rd_list) * LIST_DEPTH + int'(rd_idx);

    always_comb begin
        len_d = len_q;
        if (len_we && !lock)
            len_d[int'(wr_list)*LEN_W +: LEN_W] = wr_len;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) len_q <= '0;
        else        len_q <= len_d;
    end

    always_ff @(posedge clk) begin
        if (ent_we && !lock)
            ent_q[waddr] <= wr_ent;
    end

    assign rd_ent = ent_q[raddr];
    assign rd_len = len_q[int'(rd_list)*LEN_W +: LEN_W];

    // R10: the length table cannot change while a transfer holds the lock
    a_r10_len_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        lock |=> $stable(len_q));
endmodule

// File: rtl/lsbt_ctrl.sv
`timescale 1ns/1ps
module lsbt_ctrl
    import lsbt_pkg::*;
#(
    parameter int WORD_CLKS  = 250,
    parameter int LIST_DEPTH = 64,
    parameter int NUM_LISTS  = 4,
    parameter int CNT_W      = 16,
    localparam int IDX_W  = $clog2(LIST_DEPTH),
    localparam int LEN_W  = IDX_W + 1,
    localparam int LSEL_W = $clog2(NUM_LISTS)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               lw_ent_en,
    input  logic               lw_len_en,
    input  logic [LSEL_W-1:0]  lw_list,
    input  logic [IDX_W-1:0]   lw_idx,
    input  logic [ENTRY_W-1:0] lw_entry,
    input  logic [LEN_W-1:0]   lw_len,
    input  logic               cmd_valid,
    output logic               cmd_ready,
    input  logic               cmd_list_mode,
    input  logic               cmd_write,
    input  logic [LSEL_W-1:0]  cmd_list,
    input  logic [CNT_W-1:0]   cmd_count,
    input  logic [MOD_W-1:0]   cmd_mod,
    input  logic [FN_W-1:0]    cmd_fn,
    input  logic [SUB_W-1:0]   cmd_sub,
    input  logic               in_valid,
    output logic               in_ready,
    input  logic [DATA_W-1:0]  in_data,
    output logic               out_valid,
    input  logic               out_ready,
    output logic [DATA_W-1:0]  out_data,
    output logic               bp_strobe,
    output logic               bp_write,
    output logic [MOD_W-1:0]   bp_mod,
    output logic [FN_W-1:0]    bp_fn,
    output logic [SUB_W-1:0]   bp_sub,
    output logic [DATA_W-1:0]  bp_wdata,
    input  logic [DATA_W-1:0]  bp_rdata,
    input  logic               bp_noresp,
    output logic               busy,
    output logic               done,
    output logic               err
);
    typedef struct packed {
        xfer_st_t           st;
        logic [CNT_W-1:0]   left;
        logic [IDX_W-1:0]   idx;
        logic [LSEL_W-1:0]  lsel;
        logic               lmode;
        logic               wr;
        bp_addr_t           fixed;
        logic               stb;
        logic               bp_wr;
        bp_addr_t           addr;
        logic [DATA_W-1:0]  wdata;
        logic               ov;
        logic [DATA_W-1:0]  odata;
        logic               done;
        logic               err;
    } regs_t;

    regs_t q, d;

    logic               slot, issue, accept;
    logic [ENTRY_W-1:0] rd_ent;
    logic [LEN_W-1:0]   rd_len;
    logic               wrap;

    lsbt_pace #(.WORD_CLKS(WORD_CLKS)) u_pace (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (accept),
        .fire  (issue),
        .slot  (slot)
    );

    lsbt_list_mem #(.LIST_DEPTH(LIST_DEPTH), .NUM_LISTS(NUM_LISTS)) u_mem (
        .clk     (clk),
        .rst_n   (rst_n),
        .lock    (busy),
        .ent_we  (lw_ent_en),
        .len_we  (lw_len_en),
        .wr_list (lw_list),
        .wr_idx  (lw_idx),
        .wr_ent  (lw_entry),
        .wr_len  (lw_len),
        .rd_list (q.lsel),
        .rd_idx  (q.idx),
        .rd_ent  (rd_ent),
        .rd_len  (rd_len)
    );

    assign accept = cmd_valid && (q.st == ST_IDLE);
    assign issue  = (q.st == ST_RUN) && slot && (q.wr ? in_valid : !q.ov);
    assign wrap   = (LEN_W'(q.idx) + LEN_W'(1)) >= rd_len;

    always_comb begin
        d      = q;
        d.stb  = 1'b0;
        d.done = 1'b0;
        if (q.ov && out_ready)
            d.ov = 1'b0;
        unique case (q.st)
            ST_IDLE: begin
                if (cmd_valid) begin
                    d.err   = 1'b0;
                    d.lsel  = cmd_list;
                    d.lmode = cmd_list_mode;
                    d.wr    = cmd_write;
                    d.fixed = '{modn: cmd_mod, fn: cmd_fn, sub: cmd_sub};
                    d.idx   = '0;
                    d.left  = cmd_count;
                    if (cmd_count == '0) d.done = 1'b1;
                    else                 d.st   = ST_RUN;
                end
            end
            ST_RUN: begin
                if (issue) begin
                    d.stb   = 1'b1;
                    d.bp_wr = q.wr;
                    d.addr  = q.lmode ? bp_addr_t'(rd_ent) : q.fixed;
                    if (q.wr) d.wdata = in_data;
                    d.idx   = wrap ? '0 : q.idx + 1'b1;
                    d.st    = ST_STB;
                end
            end
            ST_STB: begin
                if (bp_noresp) begin
                    d.err  = 1'b1;
                    d.done = 1'b1;
                    d.st   = ST_IDLE;
                end else begin
                    if (!q.bp_wr) begin
                        d.ov    = 1'b1;
                        d.odata = bp_rdata;
                    end
                    d.left = q.left - 1'b1;
                    if (q.left == CNT_W'(1)) begin
                        d.done = 1'b1;
                        d.st   = ST_IDLE;
                    end else begin
                        d.st   = ST_RUN;
                    end
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign cmd_ready = (q.st == ST_IDLE);
    assign busy      = (q.st != ST_IDLE);
    assign in_ready  = (q.st == ST_RUN) && slot && q.wr;
    assign out_valid = q.ov;
    assign out_data  = q.odata;
    assign bp_strobe = q.stb;
    assign bp_write  = q.bp_wr;
    assign bp_mod    = q.addr.modn;
    assign bp_fn     = q.addr.fn;
    assign bp_sub    = q.addr.sub;
    assign bp_wdata  = q.wdata;
    assign done      = q.done;
    assign err       = q.err;

    a_r7_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
        bp_strobe |=> !bp_strobe);
    a_r9_noresp_aborts: assert property (@(posedge clk) disable iff (!rst_n)
        (bp_strobe && bp_noresp) |=> (done && err && !busy));
    a_r3_out_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
    a_r8_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);
    a_r2_in_write_only: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |-> (busy && !bp_strobe));
endmodule

// File: tb/lsbt_ctrl_tb.sv
`timescale 1ns/1ps
module lsbt_ctrl_tb;
    localparam int P = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic lw_ent_en = 0, lw_len_en = 0;
    logic [1:0] lw_list = 0;
    logic [5:0] lw_idx = 0;
    logic [13:0] lw_entry = 0;
    logic [6:0] lw_len = 0;
    logic cmd_valid = 0, cmd_list_mode = 0, cmd_write = 0;
    logic cmd_ready;
    logic [1:0] cmd_list = 0;
    logic [15:0] cmd_count = 0;
    logic [4:0] cmd_mod = 0, cmd_fn = 0;
    logic [3:0] cmd_sub = 0;
    logic in_valid = 0, in_ready;
    logic [23:0] in_data = 0;
    logic out_valid, out_ready = 1;
    logic [23:0] out_data;
    logic bp_strobe, bp_write;
    logic [4:0] bp_mod, bp_fn;
    logic [3:0] bp_sub;
    logic [23:0] bp_wdata;
    logic [23:0] bp_rdata = 0;
    logic bp_noresp = 0;
    logic busy, done, err;

    always #2 clk = ~clk;

    lsbt_ctrl #(.WORD_CLKS(P), .LIST_DEPTH(64), .NUM_LISTS(4), .CNT_W(16)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .lw_ent_en(lw_ent_en), .lw_len_en(lw_len_en), .lw_list(lw_list),
        .lw_idx(lw_idx), .lw_entry(lw_entry), .lw_len(lw_len),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_list_mode(cmd_list_mode),
        .cmd_write(cmd_write), .cmd_list(cmd_list), .cmd_count(cmd_count),
        .cmd_mod(cmd_mod), .cmd_fn(cmd_fn), .cmd_sub(cmd_sub),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
        .bp_strobe(bp_strobe), .bp_write(bp_write), .bp_mod(bp_mod), .bp_fn(bp_fn),
        .bp_sub(bp_sub), .bp_wdata(bp_wdata), .bp_rdata(bp_rdata),
        .bp_noresp(bp_noresp), .busy(busy), .done(done), .err(err)
    );

    int total = 0, bad = 0, cyc = 0;
    int exp_len [4];
    bit mon_on = 0;
    bit cur_mode = 0, cur_write = 0, cur_gap = 0, cur_stall = 0;
    int cur_list = 0, cur_abort = -1, xid = 0;
    logic [13:0] cur_fixed = 0;
    string cur_tag = "R5";
    int stb_n = 0, last_stb = 0, out_n = 0, sent = 0, done_n = 0;
    bit hs_pend = 0;

    function automatic logic [13:0] ent_of(int l, int i);
        return {5'((l * 7 + i * 3) % 32), 5'((i * 5 + l + 1) % 32), 4'((i + l * 3) % 16)};
    endfunction
    function automatic logic [23:0] wpat(int x, int k);
        return 24'(32'hA50000 ^ (k * 32'h1357) ^ (x << 12));
    endfunction
    function automatic logic [23:0] rpat(int x, int k);
        return 24'(32'h3C0F00 + k * 32'h0421 + x * 32'h10001);
    endfunction

    task automatic chk(bit ok, string req, string what, int act, int expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s act=%0h exp=%0h", req, what, act, expv);
        end
    endtask

    // Monitor and stream driver, evaluated at every falling edge
    always @(negedge clk) begin
        cyc++;
        if (rst_n && mon_on) begin
            if (bp_strobe) begin
                automatic int len = (exp_len[cur_list] < 1) ? 1 : exp_len[cur_list];
                automatic logic [13:0] ea = cur_mode ? ent_of(cur_list, stb_n % len) : cur_fixed;
                chk({bp_mod, bp_fn, bp_sub} == ea, cur_tag, "strobe address",
                    int'({bp_mod, bp_fn, bp_sub}), int'(ea));
                chk(bp_write == cur_write, "R2", "strobe direction", int'(bp_write), int'(cur_write));
                if (cur_write)
                    chk(bp_wdata == wpat(xid, stb_n), "R2", "write data",
                        int'(bp_wdata), int'(wpat(xid, stb_n)));
                if (stb_n > 0) begin
                    if (cur_gap || cur_stall)
                        chk(cyc - last_stb >= P, "R7", "min strobe gap", cyc - last_stb, P);
                    else
                        chk(cyc - last_stb == P, "R7", "strobe gap", cyc - last_stb, P);
                end
                bp_rdata  = rpat(xid, stb_n);
                bp_noresp = (stb_n == cur_abort);
                last_stb  = cyc;
                stb_n++;
            end else begin
                bp_noresp = 1'b0;
            end
            out_ready = cur_stall ? (cyc % 3 == 0) : 1'b1;
            if (out_valid && out_ready) begin
                chk(out_data == rpat(xid, out_n), "R3", "read word",
                    int'(out_data), int'(rpat(xid, out_n)));
                out_n++;
            end
            if (hs_pend) sent++;
            in_valid = cur_write && (cur_gap ? (cyc % 5 >= 2) : 1'b1);
            in_data  = wpat(xid, sent);
            hs_pend  = in_valid && in_ready;
            if (done) done_n++;
        end
    end

    task automatic tick();
        @(negedge clk);
        #1;
    endtask

    task automatic load_entry(int l, int i, logic [13:0] e);
        tick();
        lw_ent_en = 1; lw_list = 2'(l); lw_idx = 6'(i); lw_entry = e;
        tick();
        lw_ent_en = 0;
    endtask

    task automatic load_len(int l, int n);
        tick();
        lw_len_en = 1; lw_list = 2'(l); lw_len = 7'(n);
        tick();
        lw_len_en = 0;
    endtask

    task automatic run(bit lm, bit wr, int l, int cnt, logic [13:0] fx,
                       int abort, bit gaps, bit stall, string tag);
        int waitc;
        int exp_stb;
        tick();
        xid++;
        cur_mode = lm; cur_write = wr; cur_list = l; cur_fixed = fx;
        cur_abort = abort; cur_gap = gaps; cur_stall = stall; cur_tag = tag;
        stb_n = 0; out_n = 0; sent = 0; done_n = 0; hs_pend = 0;
        mon_on = 1;
        cmd_list_mode = lm; cmd_write = wr; cmd_list = 2'(l); cmd_count = 16'(cnt);
        {cmd_mod, cmd_fn, cmd_sub} = fx;
        cmd_valid = 1;
        tick();
        cmd_valid = 0;
        chk(err == 1'b0, "R9", "err cleared by new command", int'(err), 0);
        waitc = 0;
        while (done_n == 0 && waitc < 3000) begin
            tick();
            waitc++;
        end
        chk(done_n > 0, "R8", "done seen", done_n, 1);
        repeat (20) tick();
        exp_stb = (abort >= 0) ? abort + 1 : cnt;
        chk(stb_n == exp_stb, (cnt == 0) ? "R11" : "R8", "strobe count", stb_n, exp_stb);
        chk(done_n == 1, "R8", "single done pulse", done_n, 1);
        chk(busy == 1'b0 && cmd_ready == 1'b1, "R8", "idle after done", int'(busy), 0);
        chk(err == (abort >= 0), "R9", "err flag", int'(err), int'(abort >= 0));
        chk(out_n == (wr ? 0 : ((abort >= 0) ? abort : cnt)), "R3", "read words delivered",
            out_n, wr ? 0 : ((abort >= 0) ? abort : cnt));
        chk(sent == (wr ? exp_stb : 0), "R2", "input words taken", sent, wr ? exp_stb : 0);
        mon_on = 0;
    endtask

    bit finished = 0;

    initial begin
        #(4 * 150000);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL R8 watchdog act=hung exp=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        exp_len[0] = 5; exp_len[1] = 3; exp_len[2] = 1; exp_len[3] = 64;
        repeat (4) tick();
        rst_n = 1;
        tick();
        // R1 reset state
        chk(cmd_ready == 1'b1, "R1", "cmd_ready", int'(cmd_ready), 1);
        chk(busy == 1'b0, "R1", "busy", int'(busy), 0);
        chk(bp_strobe == 1'b0, "R1", "bp_strobe", int'(bp_strobe), 0);
        chk(done == 1'b0 && err == 1'b0, "R1", "done/err", int'({done, err}), 0);
        chk(out_valid == 1'b0 && in_ready == 1'b0, "R1", "streams", int'({out_valid, in_ready}), 0);

        for (int l = 0; l < 4; l++) begin
            for (int i = 0; i < 64; i++) load_entry(l, i, ent_of(l, i));
            load_len(l, exp_len[l]);
        end

        // R5 / R6: list-mode writes that wrap every list
        for (int l = 0; l < 4; l++) run(1, 1, l, 70, 14'h0, -1, 0, 0, "R6");
        // R3 / R5: list-mode reads with a stalling consumer
        for (int l = 0; l < 4; l++) run(1, 0, l, 9, 14'h0, -1, 0, 1, "R5");
        // R4: fixed mode, write with input gaps, then plain read
        run(0, 1, 2, 12, 14'h2ABC, -1, 1, 0, "R4");
        run(0, 0, 1, 7, 14'h1357, -1, 0, 0, "R4");
        // R9: abort on the third read word, then on the first write word
        run(1, 0, 1, 10, 14'h0, 2, 0, 0, "R9");
        run(0, 1, 0, 6, 14'h0F0F, 0, 0, 0, "R9");
        // R11: empty block
        run(1, 1, 3, 0, 14'h0, -1, 0, 0, "R11");

        // R10: table writes during a running list transfer are dropped
        fork
            run(1, 1, 0, 20, 14'h0, -1, 0, 0, "R10");
            begin
                repeat (12) tick();
                for (int i = 0; i < 4; i++) load_entry(0, i, 14'h3FFF);
                load_len(0, 2);
            end
        join
        run(1, 1, 0, 12, 14'h0, -1, 0, 0, "R10");

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule